// File: doc/BRIEF.md
# Set/Clear Two-Wire Bit-Bang Port

This peripheral lets software drive a two-wire serial bus (clock and data, I2C-style) one bit at a time through a small 32-bit register interface with zero wait states. Two control bits are held in one register. One of them is for the clock wire and one is for the data wire. A write to the set offset raises the selected bits. A write to the clear offset lowers them. Neither write disturbs the other bit.

Both wires are open-drain. A control bit of 0 turns on the pad driver, which pulls the wire low. A control bit of 1 releases the wire, and the external pull-up brings it high. Reading the set offset returns the clock control bit. The data bit of that read word is the real level on the data wire, which can differ from the data control bit when another device holds the wire low. That level passes through a synchronizer first. Any access outside the mapped offsets of the 4 KiB window ends with an error response.

Top module: `twp_top`

## Requirements
- R1: After reset both control bits are 1, so neither pad driver is enabled.
- R2: A write to offset 0x000 ORs write-data bits [1:0] into the control register, where bit 0 is the clock line and bit 1 is the data line. Write-data bits [31:2] have no effect.
- R3: A write to offset 0x004 clears every control bit whose write-data bit is 1, using bit 0 for the clock line and bit 1 for the data line. Write-data bits [31:2] have no effect.
- R4: Each output enable is the inverse of its control bit. `scl_oe`=1 and `sda_oe`=1 pull their wires low.
- R5: A read of offset 0x000 returns these bits:
  - bit 0: the clock control bit.
  - bit 1: the synchronized level of `sda_in`, not the data control bit.
  - bits [31:2]: zero.
- R6: A change on `sda_in` reaches read-data bit 1 after two clock edges (two flop stages).
- R7: A read of any offset other than 0x000 returns 0xFFFFFFFF with `pslverr`=1. This covers 0x004, offsets that are not word-aligned, and the top of the 12-bit window.
- R8: A write to any offset other than 0x000 and 0x004 leaves the control register unchanged and returns `pslverr`=1.
- R9: `pready` is 1 in every access phase and 0 otherwise. `pslverr` is 0 for mapped accesses and is only ever 1 together with `pready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the 4 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (zero wait) |
| pslverr | output | 1 | Error response for unmapped offsets |
| scl_oe | output | 1 | Clock pad driver enable, 1 pulls the wire low |
| sda_oe | output | 1 | Data pad driver enable, 1 pulls the wire low |
| sda_in | input | 1 | Raw data-wire level from the pad |

## Verification
The bench builds the block with its default parameters: a 12-bit window, a 32-bit data path and a two-stage synchronizer. With these values the window's top offset 0xFFC, a misaligned offset and the full upper write-data field can all be driven directly. Read-back tests change the data-wire level in the same cycle as a read's setup phase, and then issue the next read back to back. This places the two-edge synchronizer lag exactly between two observable reads. Other reads hold the data wire high while both control bits are 0, which separates the sensed level from the driven bit.

// File: rtl/twp_pkg.sv
package twp_pkg;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_CLK  = 0;
    localparam int unsigned LINE_DAT  = 1;

    localparam logic [11:0] OFS_SET = 12'h000;
    localparam logic [11:0] OFS_CLR = 12'h004;

    typedef struct packed {
        logic access;
        logic wr_set;
        logic wr_clr;
        logic rd_ok;
        logic fault;
    } dec_t;

    typedef struct packed {
        logic [NUM_LINES-1:0] ctrl;
    } ctrl_state_t;

endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q = chain_q[LAST];

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R6
    first_stage_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> chain_q[0] == $past(d));

endmodule

// File: rtl/twp_decode.sv
module twp_decode
    import twp_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_set    = (paddr == A_SET);
        hit_clr    = (paddr == A_CLR);
        dec        = '0;
        dec.access = psel && penable;
        if (dec.access) begin
            if (pwrite) begin
                dec.wr_set = hit_set;
                dec.wr_clr = hit_clr;
                dec.fault  = !(hit_set || hit_clr);
            end else begin
                dec.rd_ok  = hit_set;
                dec.fault  = !hit_set;
            end
        end
    end

endmodule

// File: rtl/twp_ctrl.sv
module twp_ctrl
    import twp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] ctrl
);
    ctrl_state_t st_d;
    ctrl_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) st_d.ctrl = st_q.ctrl | mask;
        if (clr_we) st_d.ctrl = st_q.ctrl & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctrl <= '1;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // R8
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(ctrl));

    // R2
    set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((ctrl & $past(mask)) == $past(mask)) && ((ctrl | $past(ctrl)) == ctrl));

    // R3
    clr_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((ctrl & $past(mask)) == '0) && ((ctrl & ~$past(mask)) == ($past(ctrl) & ~$past(mask))));

endmodule

// File: rtl/twp_top.sv
module twp_top
    import twp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    dec_t                 dec;
    logic [NUM_LINES-1:0] ctrl;
    logic [NUM_LINES-1:0] oe;
    logic                 sda_sense;

    twp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .dec     (dec)
    );

    twp_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (dec.wr_set),
        .clr_we (dec.wr_clr),
        .mask   (pwdata[NUM_LINES-1:0]),
        .ctrl   (ctrl)
    );

    twp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_sense)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_pad
            assign oe[g] = ~ctrl[g];
        end
    endgenerate

    assign scl_oe = oe[LINE_CLK];
    assign sda_oe = oe[LINE_DAT];

    always_comb begin
        prdata = '0;
        if (dec.rd_ok) begin
            prdata[LINE_CLK] = ctrl[LINE_CLK];
            prdata[LINE_DAT] = sda_sense;
        end else if (dec.access && !pwrite && dec.fault) begin
            prdata = '1;
        end
    end

    assign pready  = dec.access;
    assign pslverr = dec.fault;

    // R9
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready);

    // R7
    bad_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr != ADDR_W'(OFS_SET)) |-> (prdata == '1 && pslverr));

    // R2
    upper_set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_SET)
         && pwdata[NUM_LINES-1:0] == '0 && pwdata[DATA_W-1:NUM_LINES] != '0)
        |=> $stable({scl_oe, sda_oe}));

    // R4
    oe_tracks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_CLR) && pwdata[LINE_CLK]) |=> scl_oe);

endmodule

// File: tb/test_twp_top.sv
module test_twp_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        scl_oe;
    logic        sda_oe;
    logic        sda_in = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    bit          q_chk[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    twp_top i_twp_top (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per access phase
    always @(negedge clk) begin
        if (rst_n && psel && penable) begin
            if (q_err.size() == 0) begin
                check(1'b0, "R9 unexpected access", 32'h0, 32'h1);
            end else begin
                logic [31:0] ed;
                logic        ee;
                bit          ec;
                string       et;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                ec = q_chk.pop_front();
                et = q_tag.pop_front();
                check(pready === 1'b1, {et, " pready"}, {31'h0, pready}, 32'h1);
                check(pslverr === ee, {et, " pslverr"}, {31'h0, pslverr}, {31'h0, ee});
                if (ec) check(prdata === ed, {et, " prdata"}, prdata, ed);
            end
        end else if (rst_n && psel && !penable) begin
            check(pready === 1'b0 && pslverr === 1'b0, "R9 setup phase idle", {30'h0, pready, pslverr}, 32'h0);
        end
    end

    // driver: starts at posedge+1, returns at posedge+1 after the transfer
    task automatic apb_xfer(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                            input logic [31:0] ed, input logic ee, input bit ec, input string tag);
        q_data.push_back(ed);
        q_err.push_back(ee);
        q_chk.push_back(ec);
        q_tag.push_back(tag);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd, input logic ee, input string tag);
        apb_xfer(1'b1, a, wd, 32'h0, ee, 1'b0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] ed, input logic ee, input string tag);
        apb_xfer(1'b0, a, 32'h0, ed, ee, 1'b1, tag);
    endtask

    task automatic check_oe(input logic es, input logic ed, input string tag);
        check(scl_oe === es && sda_oe === ed, tag, {30'h0, scl_oe, sda_oe}, {30'h0, es, ed});
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 R4 reset state
        check_oe(1'b0, 1'b0, "R1 reset oe released");
        rd(12'h000, 32'h3, 1'b0, "R1 R5 reset read");

        // R3 clear clock bit
        wr(12'h004, 32'h1, 1'b0, "R3 clear clk");
        check_oe(1'b1, 1'b0, "R3 R4 clk pulled low");
        rd(12'h000, 32'h2, 1'b0, "R5 clk low read");

        // R3 clear data bit; R5 read shows pin, not control
        wr(12'h004, 32'h2, 1'b0, "R3 clear dat");
        check_oe(1'b1, 1'b1, "R4 both pulled");
        rd(12'h000, 32'h2, 1'b0, "R5 sensed high while driven bit low");

        // R2 upper bits ignored on set
        wr(12'h000, 32'hFFFF_FFFC, 1'b0, "R2 set upper only");
        check_oe(1'b1, 1'b1, "R2 upper set no effect");

        // R2 set bits one at a time
        wr(12'h000, 32'h1, 1'b0, "R2 set clk");
        check_oe(1'b0, 1'b1, "R2 clk released only");
        rd(12'h000, 32'h3, 1'b0, "R5 clk high read");
        wr(12'h000, 32'h2, 1'b0, "R2 set dat");
        check_oe(1'b0, 1'b0, "R2 dat released");

        // R3 upper bits ignored on clear
        wr(12'h004, 32'hFFFF_FFFC, 1'b0, "R3 clear upper only");
        check_oe(1'b0, 1'b0, "R3 upper clear no effect");

        // R6 two-edge lag on the data wire
        sda_in = 1'b0;
        rd(12'h000, 32'h3, 1'b0, "R6 old level first read");
        rd(12'h000, 32'h1, 1'b0, "R6 new level second read");
        sda_in = 1'b1;
        rd(12'h000, 32'h1, 1'b0, "R6 rise old level");
        rd(12'h000, 32'h3, 1'b0, "R6 rise new level");

        // R7 unmapped reads
        rd(12'h004, 32'hFFFF_FFFF, 1'b1, "R7 read clear offset");
        rd(12'h008, 32'hFFFF_FFFF, 1'b1, "R7 read 0x008");
        rd(12'h001, 32'hFFFF_FFFF, 1'b1, "R7 read misaligned");
        rd(12'hFFC, 32'hFFFF_FFFF, 1'b1, "R7 read window top");

        // R8 unmapped writes leave control unchanged
        wr(12'h008, 32'h0000_0003, 1'b1, "R8 write 0x008 clear-like");
        check_oe(1'b0, 1'b0, "R8 no change from 0x008");
        wr(12'h004, 32'h3, 1'b0, "R3 clear both");
        check_oe(1'b1, 1'b1, "R3 both low");
        wr(12'hFFC, 32'h3, 1'b1, "R8 write window top");
        wr(12'h001, 32'h3, 1'b1, "R8 write misaligned");
        check_oe(1'b1, 1'b1, "R8 no change from unmapped set-like");
        rd(12'h000, 32'h2, 1'b0, "R8 R5 read after unmapped writes");

        repeat (2) @(posedge clk);
        #1;
        check(q_err.size() == 0, "R9 all accesses seen", q_err.size(), 32'h0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule